// File: doc/BRIEF.md
# Masked Write-One-to-Clear Interrupt Aggregator

This block gathers hardware event pulses into three separate groups of sticky status bits, each readable and clearable over a simple register bus. Software clears a bit by writing a one to its position. Writing a zero leaves the bit as it is. Each group has its own level interrupt request that is recomputed every cycle.

The main group pairs a status register with a mask register that software writes directly. The DMA group packs two halves into one 32-bit word. Status sits in the lower half and mask in the upper half, so one write can clear status bits and flip mask bits. Clearing status never disturbs the mask. The sub-bus group is a flag register with no mask: its request stays high while any flag is set.

Reads return the selected register in the same cycle as the address. Writes take effect at the next rising clock edge. Priority encoding, vectoring and the processor side are left to the logic that consumes the three request lines.

Top module: `irq_aggregator`

## Requirements
- R1: Reset, asserted low and asynchronous, clears every status bit, every mask bit and all three request outputs to 0.
- R2: An event input bit that is 1 at a rising edge sets the matching status bit in its group. Reads then return that bit from the edge onward: main at offset 0xF000, DMA in bits [15:0] of 0xE010, sub-bus at 0xF230.
- R3: A write to 0xF000 clears each main status bit whose data bit is 1, and leaves the bits whose data bit is 0 unchanged.
- R4: A write to 0xF010 loads the main mask with the written data, and a read of 0xF010 returns it.
- R5: `irq_main` is a registered level. From the edge that updates the state, it equals 1 exactly when main status AND main mask is nonzero.
- R6: A read of 0xE010 returns the DMA mask in bits [31:16] and the DMA status in bits [15:0].
- R7: A write to 0xE010 clears the DMA status bits that are 1 in data [15:0]. It inverts each DMA mask bit that is 1 in data [31:16]. When data [31:16] is zero, the mask is left unchanged.
- R8: `irq_dma` is a registered level equal to 1 exactly when DMA status AND DMA mask is nonzero.
- R9: A write to 0xF230 clears the sub-bus flags that are 1 in the data. `irq_sub` is 1 exactly when any sub-bus flag is set.
- R10: When an event and a clearing write hit the same bit at the same edge, the bit ends up set.
- R11: A write to any other offset changes no register and no request, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_main | input | 16 | Main group event bits |
| ev_dma | input | 16 | DMA group event bits |
| ev_sub | input | 16 | Sub-bus group event bits |
| irq_main | output | 1 | Main group request |
| irq_dma | output | 1 | DMA group request |
| irq_sub | output | 1 | Sub-bus group request |

## Verification
A hardware event and a software write-one-to-clear can arrive at the same edge on the same status bit. The bench provokes this in the main group and again in the DMA word. In each case it drives an event bit in the same cycle as a write whose data has that bit set. It judges the result by reading the register back after the edge and by checking the request line. The bit must read as set and the request must stay high, while the other bits named in the write are cleared.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int MAIN_W   = 16,
  parameter int SUB_W    = 16,
  parameter logic [ADDR_W-1:0] OFS_MAIN_ST   = 16'hF000,
  parameter logic [ADDR_W-1:0] OFS_MAIN_MASK = 16'hF010,
  parameter logic [ADDR_W-1:0] OFS_DMA       = 16'hE010,
  parameter logic [ADDR_W-1:0] OFS_SUB       = 16'hF230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [MAIN_W-1:0] ev_main,
  input  logic [DATA_W/2-1:0] ev_dma,
  input  logic [SUB_W-1:0]  ev_sub,
  output logic              irq_main,
  output logic              irq_dma,
  output logic              irq_sub
);
  localparam int HALF = DATA_W / 2;

  logic [MAIN_W-1:0] main_st, main_mask, main_st_n, main_mask_n;
  logic [HALF-1:0]   dma_st, dma_mask, dma_st_n, dma_mask_n;
  logic [SUB_W-1:0]  sub_fl, sub_fl_n;

  wire hit_main_st   = bus_addr == OFS_MAIN_ST;
  wire hit_main_mask = bus_addr == OFS_MAIN_MASK;
  wire hit_dma       = bus_addr == OFS_DMA;
  wire hit_sub       = bus_addr == OFS_SUB;

  wire wr_main_st   = bus_we && hit_main_st;
  wire wr_main_mask = bus_we && hit_main_mask;
  wire wr_dma       = bus_we && hit_dma;
  wire wr_sub       = bus_we && hit_sub;

  // Clear first, then OR in events: a same-cycle event always survives.
  assign main_st_n   = (main_st & ~(wr_main_st ? bus_wdata[MAIN_W-1:0] : '0)) | ev_main;
  assign main_mask_n = wr_main_mask ? bus_wdata[MAIN_W-1:0] : main_mask;
  assign dma_st_n    = (dma_st & ~(wr_dma ? bus_wdata[HALF-1:0] : '0)) | ev_dma;
  assign dma_mask_n  = dma_mask ^ (wr_dma ? bus_wdata[DATA_W-1:HALF] : '0);
  assign sub_fl_n    = (sub_fl & ~(wr_sub ? bus_wdata[SUB_W-1:0] : '0)) | ev_sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_st   <= '0;
      main_mask <= '0;
      dma_st    <= '0;
      dma_mask  <= '0;
      sub_fl    <= '0;
      irq_main  <= 1'b0;
      irq_dma   <= 1'b0;
      irq_sub   <= 1'b0;
    end else begin
      main_st   <= main_st_n;
      main_mask <= main_mask_n;
      dma_st    <= dma_st_n;
      dma_mask  <= dma_mask_n;
      sub_fl    <= sub_fl_n;
      irq_main  <= |(main_st_n & main_mask_n);
      irq_dma   <= |(dma_st_n & dma_mask_n);
      irq_sub   <= |sub_fl_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_main_st)        bus_rdata[MAIN_W-1:0] = main_st;
    else if (hit_main_mask) bus_rdata[MAIN_W-1:0] = main_mask;
    else if (hit_dma)       bus_rdata = {dma_mask, dma_st};
    else if (hit_sub)       bus_rdata[SUB_W-1:0] = sub_fl;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_main != '0) |=> ((main_st & $past(ev_main)) == $past(ev_main)));

  assert_w1c_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_main_st && ev_main == '0) |=> ((main_st & $past(bus_wdata[MAIN_W-1:0])) == '0));

  assert_dma_mask_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dma && bus_wdata[DATA_W-1:HALF] == '0) |=> $stable(dma_mask));

  assert_main_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_main == |(main_st & main_mask));

  assert_dma_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dma == |(dma_st & dma_mask));

  assert_sub_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sub == (sub_fl != '0));

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit_main_st && !hit_main_mask && !hit_dma && !hit_sub)
      |=> ($stable(main_mask) && $stable(dma_mask)));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ev_main = '0, ev_dma = '0, ev_sub = '0;
  logic        irq_main, irq_dma, irq_sub;
  int          n_run = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_main(ev_main),
    .ev_dma(ev_dma), .ev_sub(ev_sub), .irq_main(irq_main),
    .irq_dma(irq_dma), .irq_sub(irq_sub)
  );

  // {we, addr, wdata, ev_main, ev_dma, ev_sub, exp_rdata, exp_irq{sub,dma,main}, req}
  localparam int NV = 20;
  localparam logic [135:0] VEC [NV] = '{
    {1'b0,16'hF000,32'h0,        16'h0,   16'h0,   16'h0,   32'h00000000,3'b000,4'd1},  // R1
    {1'b0,16'hF000,32'h0,        16'h0011,16'h0,   16'h0,   32'h00000011,3'b000,4'd2},  // R2
    {1'b1,16'hF010,32'h0010,     16'h0,   16'h0,   16'h0,   32'h00000010,3'b001,4'd5},  // R4 R5
    {1'b1,16'hF000,32'h0010,     16'h0,   16'h0,   16'h0,   32'h00000001,3'b000,4'd3},  // R3
    {1'b1,16'hF000,32'h0011,     16'h0010,16'h0,   16'h0,   32'h00000010,3'b001,4'd10}, // R10
    {1'b1,16'hF000,32'hFFFF,     16'h0,   16'h0,   16'h0,   32'h00000000,3'b000,4'd3},  // R3
    {1'b0,16'hE010,32'h0,        16'h0,   16'h0005,16'h0,   32'h00000005,3'b000,4'd6},  // R6 R2
    {1'b1,16'hE010,32'h00040000, 16'h0,   16'h0,   16'h0,   32'h00040005,3'b010,4'd7},  // R7 R8
    {1'b1,16'hE010,32'h00000004, 16'h0,   16'h0,   16'h0,   32'h00040001,3'b000,4'd7},  // R7
    {1'b1,16'hE010,32'h00050000, 16'h0,   16'h0,   16'h0,   32'h00010001,3'b010,4'd7},  // R7 toggle
    {1'b1,16'hE010,32'h00000001, 16'h0,   16'h0001,16'h0,   32'h00010001,3'b010,4'd10}, // R10 dma
    {1'b1,16'hE010,32'h00000001, 16'h0,   16'h0,   16'h0,   32'h00010000,3'b000,4'd8},  // R8
    {1'b0,16'hF230,32'h0,        16'h0,   16'h0,   16'h0300,32'h00000300,3'b100,4'd9},  // R9
    {1'b1,16'hF230,32'h0100,     16'h0,   16'h0,   16'h0,   32'h00000200,3'b100,4'd9},  // R9
    {1'b1,16'hF230,32'h0200,     16'h0,   16'h0,   16'h0,   32'h00000000,3'b000,4'd9},  // R9
    {1'b0,16'hF000,32'h0,        16'h8000,16'h0,   16'h0,   32'h00008000,3'b000,4'd5},  // R5 masked
    {1'b1,16'hF100,32'hFFFFFFFF, 16'h0,   16'h0,   16'h0,   32'h00000000,3'b000,4'd11}, // R11
    {1'b0,16'hF000,32'h0,        16'h0,   16'h0,   16'h0,   32'h00008000,3'b000,4'd11}, // R11
    {1'b0,16'hF010,32'h0,        16'h0,   16'h0,   16'h0,   32'h00000010,3'b000,4'd11}, // R11
    {1'b1,16'hF010,32'h8000,     16'h0,   16'h0,   16'h0,   32'h00008000,3'b001,4'd4}   // R4
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [15:0] a, input logic [31:0] d,
                      input logic [15:0] em, input logic [15:0] ed, input logic [15:0] es);
    bus_we = we; bus_addr = a; bus_wdata = d;
    ev_main = em; ev_dma = ed; ev_sub = es;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; ev_main = '0; ev_dma = '0; ev_sub = '0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, "read", bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: state while held in reset
    read_chk("R1", 16'hF000, 32'h0);
    read_chk("R1", 16'hE010, 32'h0);
    check("R1", "irqs in reset", {29'h0, irq_sub, irq_dma, irq_main}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[3:0]);
      step(v[135], v[134:119], v[118:87], v[86:71], v[70:55], v[54:39]);
      #1;
      check(rq, $sformatf("vec %0d rdata", i), bus_rdata, v[38:7]);
      check(rq, $sformatf("vec %0d irq", i), {29'h0, irq_sub, irq_dma, irq_main}, {29'h0, v[6:4]});
    end

    // R1: reset in mid-run wipes status, masks and requests
    step(1'b0, 16'hF230, 32'h0, 16'h8000, 16'h0, 16'h0001);
    rst_n = 1'b0;
    #1;
    read_chk("R1", 16'hF000, 32'h0);
    read_chk("R1", 16'hF010, 32'h0);
    read_chk("R1", 16'hE010, 32'h0);
    read_chk("R1", 16'hF230, 32'h0);
    check("R1", "irqs after reset", {29'h0, irq_sub, irq_dma, irq_main}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R8 R9: events in all groups at one edge; requests rise at that edge, not before
    step(1'b1, 16'hF010, 32'h0001, 16'h0, 16'h0, 16'h0);
    step(1'b1, 16'hE010, 32'h00010000, 16'h0, 16'h0, 16'h0);
    ev_main = 16'h0001; ev_dma = 16'h0001; ev_sub = 16'h0001;
    #1;
    check("R5", "irq before edge", {29'h0, irq_sub, irq_dma, irq_main}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    ev_main = '0; ev_dma = '0; ev_sub = '0;
    check("R8", "irq all groups", {29'h0, irq_sub, irq_dma, irq_main}, 32'h7);
    read_chk("R2", 16'hF230, 32'h1);

    // R7: status clear with zero upper half keeps mask
    step(1'b1, 16'hE010, 32'h00000001, 16'h0, 16'h0, 16'h0);
    read_chk("R7", 16'hE010, 32'h00010000);
    read_chk("R11", 16'h0000, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule